// File: doc/BRIEF.md
# Sectioned 24-Stage Binary Counter

This block is a 24-stage binary ripple-style counter rebuilt as synchronous logic. It counts every high-to-low transition of a slow count input. That input is first brought into the system clock domain by a two-flop synchronizer and then turned into a one-cycle count strobe. Two level controls, set and clear, either force the register to a constant or switch it into a test arrangement. In that arrangement the chain breaks into three 8-bit sections that all advance on the same strobe, so that the whole register reaches all ones after only 255 edges.

In normal use both controls are low and the 24 stages form one chain with full carry. A test fill raises both controls, applies 255 edges, and then drops both controls in the same cycle. The stored all-ones value is kept, and the next edge rolls the whole chain over to zero. A one-cycle wrap flag marks that rollover of the full serial chain.

Top module: `seg24_counter`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `stages_o` becomes 0 and `wrap_o` becomes 0 from the next cycle.
- R2: With `set_i`=0 and `clr_i`=0, each high-to-low transition of `cnt_in` adds one, modulo 2^24, to the 24-bit value on `stages_o`. Each input level must be held for at least two clocks. The new value appears at the third rising `clk` edge after the transition.
- R3: A low-to-high transition of `cnt_in`, or a steady level, leaves `stages_o` unchanged.
- R4: With `clr_i`=1 and `set_i`=0, `stages_o` is 0 from the next cycle and stays 0 whatever `cnt_in` does.
- R5: With `set_i`=1 and `clr_i`=0, every bit of `stages_o` is 1 from the next cycle and stays 1 whatever `cnt_in` does.
- R6: With `set_i`=1 and `clr_i`=1, the fields [7:0], [15:8] and [23:16] each add one, modulo 256, on every falling edge, with no carry between fields. Starting from 0, 255 edges give all ones, and one more edge returns every field to 0.
- R7: When both controls fall together, the stored value is kept. The next falling edge counts it with the full serial carry. This also holds when the controls fall in the same cycle that the edge's count strobe is active.
- R8: `wrap_o` is high for exactly one cycle, in the cycle after a serial count that moves `stages_o` from all ones to 0. It never rises for a wrap in split mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 1 | Count input, advances on its falling edge |
| set_i | input | 1 | Set control; with clr_i selects fill or split mode |
| clr_i | input | 1 | Clear control; alone forces all stages to 0 |
| stages_o | output | 24 | Registered value of all stages |
| wrap_o | output | 1 | One-cycle pulse on a serial all-ones to zero rollover |

## Verification
The count strobe from a falling edge and a change of the mode controls can both take effect on the same clock edge. The case that matters most is both controls dropping together while the strobe is active. The bench provokes this by timing the input fall so that the controls drop between the second and third clock edges after it. From a split-mode all-ones state, the serial rule must then govern: the register must read 0 and the wrap flag must be high in the following cycle. A second collision, edges arriving during a forced clear or fill, is judged by requiring the forced value to stay put.

// File: rtl/seg24_pkg.sv
package seg24_pkg;
  // Mode encoding is {set, clr}
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_FILL  = 2'b10,
    MODE_SPLIT = 2'b11
  } mode_e;

  function automatic mode_e decode_mode(input logic set_b, input logic clr_b);
    return mode_e'({set_b, clr_b});
  endfunction
endpackage

// File: rtl/seg24_fall_det.sv
module seg24_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      prev_q <= sync_q[MSB];
    end
  end

  assign fall_o = prev_q & ~sync_q[MSB];

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/seg24_section.sv
module seg24_section
  import seg24_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_e        mode,
  input  logic         cnt_en,
  output logic [W-1:0] q_o,
  output logic         full_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (mode)
        MODE_CLEAR: q <= '0;
        MODE_FILL:  q <= '1;
        default:    if (cnt_en) q <= q + 1'b1;
      endcase
    end
  end

  assign q_o    = q;
  assign full_o = &q;

  // R6
  section_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_RUN || mode == MODE_SPLIT) && cnt_en)
      |=> q == W'($past(q) + 1'b1));

  // R3
  section_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_RUN || mode == MODE_SPLIT) && !cnt_en) |=> $stable(q));
endmodule

// File: rtl/seg24_counter.sv
module seg24_counter
  import seg24_pkg::*;
#(
  parameter int SEC_W       = 8,
  parameter int NUM_SEC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cnt_in,
  input  logic                     set_i,
  input  logic                     clr_i,
  output logic [SEC_W*NUM_SEC-1:0] stages_o,
  output logic                     wrap_o
);
  localparam int W = SEC_W * NUM_SEC;

  mode_e            mode;
  logic             fall;
  logic             split;
  logic [NUM_SEC:0] low_full;
  logic             wrap_q;

  assign mode        = decode_mode(set_i, clr_i);
  assign split       = (mode == MODE_SPLIT);
  assign low_full[0] = 1'b1;

  seg24_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
    .clk    (clk),
    .rst    (rst),
    .din    (cnt_in),
    .fall_o (fall)
  );

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic [SEC_W-1:0] q;
    logic             full;
    logic             en;

    assign en = fall & (split | low_full[s]);

    seg24_section #(.W(SEC_W)) u_sec (
      .clk    (clk),
      .rst    (rst),
      .mode   (mode),
      .cnt_en (en),
      .q_o    (q),
      .full_o (full)
    );

    assign low_full[s+1]               = low_full[s] & full;
    assign stages_o[s*SEC_W +: SEC_W]  = q;
  end

  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= (mode == MODE_RUN) & fall & low_full[NUM_SEC];
  end

  assign wrap_o = wrap_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (stages_o == '0 && !wrap_o));

  // R2
  serial_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && fall) |=> stages_o == W'($past(stages_o) + 1'b1));

  // R4
  clear_force_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> stages_o == '0);

  // R5
  fill_force_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> &stages_o);

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> stages_o == '0);

  // R8
  split_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    split |=> !wrap_o);
endmodule

// File: tb/seg24_counter_tb.sv
module seg24_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst;
  logic         cnt_in;
  logic         set_i;
  logic         clr_i;
  logic [W-1:0] stages_o;
  logic         wrap_o;

  int errors = 0;
  int checks = 0;
  int wrap_seen = 0;
  int wrap_exp = 0;
  logic [W-1:0] exp_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg24_counter u_dut (
    .clk      (clk),
    .rst      (rst),
    .cnt_in   (cnt_in),
    .set_i    (set_i),
    .clr_i    (clr_i),
    .stages_o (stages_o),
    .wrap_o   (wrap_o)
  );

  always @(posedge clk) begin
    #1;
    if (wrap_o === 1'b1) wrap_seen++;
  end

  function automatic logic [W-1:0] step(input logic [W-1:0] v, input bit sp);
    if (sp) return {v[23:16] + 8'd1, v[15:8] + 8'd1, v[7:0] + 8'd1};
    return v + 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input bit s, input bit c);
    @(negedge clk);
    set_i = s;
    clr_i = c;
    @(negedge clk);
    if (c && !s) exp_val = '0;
    if (s && !c) exp_val = '1;
  endtask

  task automatic pulse();
    cnt_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_in = 1'b0;
    repeat (4) @(negedge clk);
    if (set_i == clr_i) begin
      if (!set_i && exp_val == '1) wrap_exp++;
      exp_val = step(exp_val, set_i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; cnt_in = 1'b0; set_i = 1'b0; clr_i = 1'b0;
    exp_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset value", 32'(stages_o), 32'h0);
    chk("R1 reset wrap", 32'(wrap_o), 32'h0);

    // R3: rising edge and steady high do nothing
    cnt_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 rise ignored", 32'(stages_o), 32'h0);

    // R2: serial counting
    for (int i = 0; i < 20; i++) begin
      pulse();
      chk("R2 serial count", 32'(stages_o), 32'(exp_val));
    end

    // R4: forced clear ignores edges
    set_mode(1'b0, 1'b1);
    chk("R4 clear", 32'(stages_o), 32'h0);
    pulse();
    chk("R4 clear holds", 32'(stages_o), 32'h0);

    // R6: split fill from zero
    set_mode(1'b1, 1'b1);
    pulse();
    chk("R6 split first", 32'(stages_o), 32'h010101);
    for (int i = 1; i < 255; i++) pulse();
    chk("R6 split all ones", 32'(stages_o), 32'hFFFFFF);

    // R7/R8: controls drop in the cycle the strobe is active
    cnt_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    set_i = 1'b0; clr_i = 1'b0;
    @(negedge clk);
    chk("R7 exit on edge", 32'(stages_o), 32'h0);
    chk("R8 wrap pulse", 32'(wrap_o), 32'h1);
    @(negedge clk);
    chk("R8 wrap one cycle", 32'(wrap_o), 32'h0);
    wrap_exp++;
    exp_val = '0;

    // R5: fill, then split wraps each section without the flag
    set_mode(1'b1, 1'b0);
    chk("R5 fill", 32'(stages_o), 32'hFFFFFF);
    pulse();
    exp_val = '1;
    chk("R5 fill holds", 32'(stages_o), 32'hFFFFFF);
    set_mode(1'b1, 1'b1);
    pulse();
    chk("R6 section wrap", 32'(stages_o), 32'h0);
    chk("R8 no split wrap", 32'(wrap_seen), 32'(wrap_exp));

    // R7: ordinary exit keeps value, next edge wraps serially
    set_mode(1'b1, 1'b0);
    set_mode(1'b1, 1'b1);
    set_mode(1'b0, 1'b0);
    chk("R7 value kept", 32'(stages_o), 32'hFFFFFF);
    pulse();
    chk("R7 serial after exit", 32'(stages_o), 32'h0);
    chk("R8 serial wrap", 32'(wrap_seen), 32'(wrap_exp));

    // Random mix
    for (int i = 0; i < 80; i++) begin
      int unsigned r = $urandom % 10;
      if (r < 6) begin
        pulse();
        chk("R2 R6 random edge", 32'(stages_o), 32'(exp_val));
      end else if (r == 6) begin
        set_mode(1'b0, 1'b0);
        chk("R7 random run", 32'(stages_o), 32'(exp_val));
      end else if (r == 7) begin
        set_mode(1'b1, 1'b1);
        chk("R7 random split", 32'(stages_o), 32'(exp_val));
      end else if (r == 8) begin
        set_mode(1'b1, 1'b0);
        chk("R5 random fill", 32'(stages_o), 32'(exp_val));
      end else begin
        set_mode(1'b0, 1'b1);
        chk("R4 random clear", 32'(stages_o), 32'(exp_val));
      end
    end
    repeat (3) @(negedge clk);
    chk("R8 random wraps", 32'(wrap_seen), 32'(wrap_exp));

    // R1: reset mid-count
    set_mode(1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; set_i = 1'b0; clr_i = 1'b0;
    chk("R1 reset again", 32'(stages_o), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule